// File: doc/BRIEF.md
# Transfer-Triggered Instruction Decoder with One-Shot Prefix

This block turns a 16-bit instruction word into a pair of selectors for a machine whose only operation is a move from a source to a destination. There is no opcode field: the destination selector names a module and an index in a space of 16 modules by 32 indexes, and the source selector does the same, or the word carries an immediate byte in place of the source. The block drives a one-hot enable to the destination module and leaves every other module's enable low. It decodes the selectors and the literal value that the register file, memories and arithmetic unit would consume. It contains none of those resources.

A single instruction word reaches only the low 8 destination indexes and the low 16 source indexes of each module. A prefix register fills the rest of the range. An instruction whose destination is the prefix module loads the prefix. For the next executed instruction only, the prefix adds the upper index bits and also supplies a high byte that turns an 8-bit literal into a 16-bit value. After that instruction the prefix clears to zero. A stall freezes the prefix, so the one-instruction lifetime counts executed words and not clock cycles.

Top module: `xfer_decoder`

## Requirements
- R1: While reset is asserted, and after it, the prefix state is zero: `pfx_active` is 0, `lit_value[15:8]` is 0 and no destination enable is high.
- R2: Register-source word (bit 15 = 1): `dst_mod` = bits 11:8, `dst_idx[2:0]` = bits 14:12, `src_mod` = bits 3:0, `src_idx[3:0]` = bits 7:4, and `src_lit` = 0.
- R3: Literal word (bit 15 = 0): `src_lit` = 1, `lit_value[7:0]` = bits 7:0, and `src_mod` and `src_idx` are both 0.
- R4: With no prefix active, `dst_idx[4:3]` = 0, `src_idx[4]` = 0 and `lit_value[15:8]` = 0.
- R5: An executed word (stall low) with `dst_mod` equal to the prefix module (default 11) loads the prefix. The code n = bits 14:12 is stored. The data byte is bits 7:0 for a literal word and 00h for a register-source word. `pfx_active` reads 1 from the next cycle.
- R6: While a prefix is active, `dst_idx[4:3]` = n[2:1] and, for a register source, `src_idx[4]` = n[0].
- R7: While a prefix is active, `lit_value` = {prefix data byte, bits 7:0}.
- R8: The prefix covers exactly one executed word and then returns to inactive with data 00h. If that word is itself a prefix load, the new prefix replaces the old one.
- R9: While `stall` is high, the prefix state holds, every `dst_en` bit is 0, and the selectors still show the decode of the presented word.
- R10: When stall and reset are both low, `dst_en` is one-hot with bit `dst_mod` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Current word does not execute this cycle |
| instr | input | 16 | Fetched instruction word |
| src_lit | output | 1 | Source is the immediate byte |
| src_mod | output | 4 | Source module (0 for literals) |
| src_idx | output | 5 | Source index, prefix-extended (0 for literals) |
| dst_mod | output | 4 | Destination module |
| dst_idx | output | 5 | Destination index, prefix-extended |
| dst_en | output | 16 | One-hot destination module enable |
| lit_value | output | 16 | Prefix data byte joined to the immediate byte |
| pfx_active | output | 1 | A prefix applies to the current word |

## Verification
Two functions can act in the same cycle: the expiry of an active prefix and the loading of a new one. The bench provokes this with two prefix-load words in a row. It then checks that the second word's own destination index is extended by the first prefix, and that the word after it sees the second prefix's code and data and not zeros. A second overlap is a stall that lands while a prefix is active. Stalled cycles are inserted between a prefix load and its consumer, and the bench checks that the extension survives them and still expires after the one executed word.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int WORD_W  = 16;
  localparam int MOD_W   = 4;
  localparam int NUM_MOD = 1 << MOD_W;
  localparam int DLO_W   = 3;
  localparam int SLO_W   = 4;
  localparam int DHI_W   = 2;
  localparam int SHI_W   = 1;
  localparam int IDX_W   = DLO_W + DHI_W;
  localparam int BYTE_W  = 8;
  localparam int PCODE_W = DHI_W + SHI_W;

  typedef struct packed {
    logic             reg_src;
    logic [DLO_W-1:0] dlo;
    logic [MOD_W-1:0] dmod;
    logic [SLO_W-1:0] slo;
    logic [MOD_W-1:0] smod;
  } word_t;

  function automatic logic [IDX_W-1:0] ext_dst(input logic [DHI_W-1:0] hi,
                                               input logic [DLO_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [IDX_W-1:0] ext_src(input logic [SHI_W-1:0] hi,
                                               input logic [SLO_W-1:0] lo);
    return {{(IDX_W-SLO_W-SHI_W){1'b0}}, hi, lo};
  endfunction

  function automatic logic [2*BYTE_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                     input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/xfer_prefix_reg.sv
module xfer_prefix_reg
  import xfer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec,
  input  logic               load,
  input  logic [PCODE_W-1:0] code_in,
  input  logic [BYTE_W-1:0]  data_in,
  output logic               valid_q,
  output logic [PCODE_W-1:0] code_q,
  output logic [BYTE_W-1:0]  data_q
);
  logic expire_ev;
  logic load_ev;

  assign load_ev   = exec & load;
  assign expire_ev = exec & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      data_q  <= '0;
    end else if (load_ev) begin
      valid_q <= 1'b1;
      code_q  <= code_in;
      data_q  <= data_in;
    end else if (expire_ev) begin
      valid_q <= 1'b0;
      code_q  <= '0;
      data_q  <= '0;
    end
  end

  // R5: an executed prefix write makes the prefix active with its code and data
  p_load_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (valid_q && code_q == $past(code_in) && data_q == $past(data_in)));

  // R8: an executed non-prefix word leaves the prefix cleared
  p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> (!valid_q && code_q == '0 && data_q == '0));

  // R9: a stalled cycle freezes the prefix state
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(valid_q) && $stable(code_q) && $stable(data_q)));
endmodule

// File: rtl/xfer_dst_enable.sv
module xfer_dst_enable
  import xfer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec,
  input  logic [MOD_W-1:0]   mod_sel,
  output logic [NUM_MOD-1:0] en
);
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    assign en[m] = exec & (mod_sel == MOD_W'(m));
  end

  // R10: at most one module is enabled, and exactly the selected one when executing
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec |-> ($onehot0(en) && en[mod_sel]));

  // R9: no module switches while the word does not execute
  p_quiet_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |-> ($countones(en) == 0));
endmodule

// File: rtl/xfer_decoder.sv
module xfer_decoder
  import xfer_pkg::*;
#(
  parameter logic [3:0] PFX_MODULE = 4'hB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic [15:0] instr,
  output logic        src_lit,
  output logic [3:0]  src_mod,
  output logic [4:0]  src_idx,
  output logic [3:0]  dst_mod,
  output logic [4:0]  dst_idx,
  output logic [15:0] dst_en,
  output logic [15:0] lit_value,
  output logic        pfx_active
);
  word_t              w;
  logic               exec;
  logic               pfx_write;
  logic [PCODE_W-1:0] pfx_code;
  logic [BYTE_W-1:0]  pfx_data;
  logic [BYTE_W-1:0]  pfx_data_in;
  logic [DHI_W-1:0]   dst_hi;
  logic [SHI_W-1:0]   src_hi;

  assign w         = word_t'(instr);
  assign exec      = rst_n & ~stall;
  assign pfx_write = (w.dmod == PFX_MODULE);
  assign pfx_data_in = w.reg_src ? '0 : {w.slo, w.smod};

  xfer_prefix_reg u_pfx (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec    (exec),
    .load    (pfx_write),
    .code_in (w.dlo),
    .data_in (pfx_data_in),
    .valid_q (pfx_active),
    .code_q  (pfx_code),
    .data_q  (pfx_data)
  );

  assign dst_hi = pfx_code[PCODE_W-1 -: DHI_W];
  assign src_hi = pfx_code[SHI_W-1:0];

  always_comb begin
    src_lit   = ~w.reg_src;
    dst_mod   = w.dmod;
    dst_idx   = ext_dst(dst_hi, w.dlo);
    lit_value = join_bytes(pfx_data, {w.slo, w.smod});
    if (w.reg_src) begin
      src_mod = w.smod;
      src_idx = ext_src(src_hi, w.slo);
    end else begin
      src_mod = '0;
      src_idx = '0;
    end
  end

  xfer_dst_enable u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec    (exec),
    .mod_sel (w.dmod),
    .en      (dst_en)
  );

  // R4: with no prefix the extension bits and the literal high byte are zero
  p_no_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_active |-> (dst_idx[4:3] == 2'b00 && src_idx[4] == 1'b0 && lit_value[15:8] == 8'h00));

  // R3: a literal source never presents a register selector
  p_lit_no_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_lit |-> (src_mod == '0 && src_idx == '0));

  // R1: reset clears prefix and silences the enables
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (dst_en == '0);
    end
  end
endmodule

// File: tb/xfer_decoder_test.sv
module xfer_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [15:0] instr = 16'h8000;
  logic        src_lit;
  logic [3:0]  src_mod;
  logic [4:0]  src_idx;
  logic [3:0]  dst_mod;
  logic [4:0]  dst_idx;
  logic [15:0] dst_en;
  logic [15:0] lit_value;
  logic        pfx_active;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [3:0] PMOD = 4'hB;

  // reference prefix state kept by the bench
  bit       m_valid = 0;
  bit [2:0] m_code = 0;
  bit [7:0] m_data = 0;

  always #2 clk = ~clk;

  xfer_decoder uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
    .src_lit(src_lit), .src_mod(src_mod), .src_idx(src_idx),
    .dst_mod(dst_mod), .dst_idx(dst_idx), .dst_en(dst_en),
    .lit_value(lit_value), .pfx_active(pfx_active)
  );

  function automatic logic [15:0] mk(input bit regsrc, input bit [2:0] dlo,
                                     input bit [3:0] dmod, input bit [7:0] src);
    logic [15:0] r;
    r[15]    = regsrc;
    r[14:12] = dlo;
    r[11:8]  = dmod;
    r[7:0]   = src;
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // present one word, check every output against the reference, then clock it
  task automatic step(input logic [15:0] wd, input bit st, input string tag);
    bit lit;
    logic [4:0]  e_didx;
    logic [4:0]  e_sidx;
    logic [3:0]  e_smod;
    logic [15:0] e_lv;
    logic [15:0] e_en;
    @(negedge clk);
    instr = wd;
    stall = st;
    #1;
    lit    = ~wd[15];
    e_didx = {(m_valid ? m_code[2:1] : 2'b00), wd[14:12]};
    e_sidx = lit ? 5'd0 : {(m_valid ? m_code[0] : 1'b0), wd[7:4]};
    e_smod = lit ? 4'd0 : wd[3:0];
    e_lv   = {(m_valid ? m_data : 8'h00), wd[7:0]};
    e_en   = st ? 16'h0 : (16'h1 << wd[11:8]);
    chk(tag, "pfx_active", 32'(pfx_active), 32'(m_valid));
    chk(tag, "src_lit",    32'(src_lit),    32'(lit));
    chk(tag, "dst_mod",    32'(dst_mod),    32'(wd[11:8]));
    chk(tag, "dst_idx",    32'(dst_idx),    32'(e_didx));
    chk(tag, "src_mod",    32'(src_mod),    32'(e_smod));
    chk(tag, "src_idx",    32'(src_idx),    32'(e_sidx));
    chk(tag, "lit_value",  32'(lit_value),  32'(e_lv));
    chk(tag, "dst_en",     32'(dst_en),     32'(e_en));
    @(posedge clk);
    if (!st) begin
      if (wd[11:8] == PMOD) begin
        m_valid = 1;
        m_code  = wd[14:12];
        m_data  = lit ? wd[7:0] : 8'h00;
      end else begin
        m_valid = 0;
        m_code  = 0;
        m_data  = 0;
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    instr = mk(0, 3'd7, PMOD, 8'hC3);
    #1;
    chk("R1", "pfx_active in reset", 32'(pfx_active), 0);
    chk("R1", "lit high in reset", 32'(lit_value[15:8]), 0);
    chk("R1", "dst_en in reset", 32'(dst_en), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    m_valid = 0; m_code = 0; m_data = 0;
    step(mk(1, 3'd2, 4'h3, 8'h45), 0, "R1");
  endtask

  task automatic t_fields;
    step(mk(1, 3'd5, 4'h2, 8'h9E), 0, "R2");
    step(mk(1, 3'd7, 4'hF, 8'hF0), 0, "R2");
    step(mk(1, 3'd0, 4'h0, 8'h0F), 0, "R4");
  endtask

  task automatic t_literal;
    step(mk(0, 3'd1, 4'h6, 8'hFF), 0, "R3");
    step(mk(0, 3'd6, 4'h9, 8'h00), 0, "R3");
  endtask

  task automatic t_pfx_load;
    step(mk(0, 3'b011, PMOD, 8'hA5), 0, "R5");
    step(mk(1, 3'd4, 4'h1, 8'h7C), 0, "R5");
    step(mk(1, 3'b110, PMOD, 8'h33), 0, "R5");
    step(mk(0, 3'd2, 4'h4, 8'h18), 0, "R5");
  endtask

  task automatic t_pfx_ext;
    for (int n = 0; n < 8; n++) begin
      step(mk(0, 3'(n), PMOD, 8'h00), 0, "R6");
      step(mk(1, 3'd7, 4'h5, 8'hE2), 0, "R6");
    end
  endtask

  task automatic t_pfx_lit;
    step(mk(0, 3'd0, PMOD, 8'h12), 0, "R7");
    step(mk(0, 3'd3, 4'h7, 8'h34), 0, "R7");
    step(mk(0, 3'd0, 4'h7, 8'h56), 0, "R7");
  endtask

  task automatic t_expiry;
    step(mk(0, 3'b111, PMOD, 8'hBE), 0, "R8");
    step(mk(0, 3'b010, PMOD, 8'hEF), 0, "R8");
    step(mk(1, 3'd1, 4'hC, 8'hA1), 0, "R8");
    step(mk(1, 3'd1, 4'hC, 8'hA1), 0, "R8");
  endtask

  task automatic t_stall;
    step(mk(0, 3'b101, PMOD, 8'h9C), 0, "R9");
    step(mk(1, 3'd3, 4'h2, 8'h5D), 1, "R9");
    step(mk(0, 3'd0, PMOD, 8'h11), 1, "R9");
    step(mk(1, 3'd3, 4'h2, 8'h5D), 0, "R9");
    step(mk(0, 3'd4, 4'h8, 8'h77), 1, "R9");
    step(mk(0, 3'd4, 4'h8, 8'h77), 0, "R9");
  endtask

  task automatic t_onehot;
    for (int m = 0; m < 16; m++) begin
      step(mk(1, 3'(m % 8), 4'(m), 8'(m * 17)), 0, "R10");
    end
  endtask

  initial begin
    t_reset();
    t_fields();
    t_literal();
    t_pfx_load();
    t_pfx_ext();
    t_pfx_lit();
    t_expiry();
    t_stall();
    t_onehot();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule